// File: doc/BRIEF.md
# Sampling Converter Digital Front End

This block models the digital side of a 16-bit sampling converter. It watches an active-low chip select and an active-low read/convert strobe, waits until both have been low for long enough, and treats that as a start of conversion. At that moment it freezes the sample that arrives on a plain test port. It then holds an active-low busy flag for a fixed number of clock cycles and stores the result when the conversion ends. After that, a short acquisition window has to pass before a new start is accepted.

Software or a host state machine reads the result over a 16-bit bus. The bus is driven only while chip select is low and read/convert is high; at all other times the output-enable flag is low and the bus reads zero. A lane-swap input exchanges the two bytes so that a host on an 8-bit bus can fetch the word in two reads. A parameter chooses the output coding: straight binary, or two's complement formed by inverting the top bit.

All durations are given in system clock cycles. The defaults correspond to 40 ns, 7 µs and 1 µs at 250 MHz.

Top module: `samp_conv_if`

## Requirements
- R1: A start is recognised only at the clock edge where `cs_n` and `rc_n` have both been sampled low on `START_CYC` consecutive edges, counting that edge. A shorter low pulse leaves `busy_n` high.
- R2: The value on `ain` at the qualifying edge is the value reported for that conversion. Changes on `ain` afterwards have no effect on that result.
- R3: Starts are ignored while a conversion runs and during the `ACQ_CYC` cycles after it ends. A low pulse held past its qualifying edge starts only one conversion, and the lines must go high again before another start can occur.
- R4: `busy_n` goes low in the cycle after the qualifying edge and stays low for exactly `CONV_CYC` cycles.
- R5: The stored result changes only at the edge where `busy_n` returns high. At that edge it takes the frozen sample.
- R6: `dout_oe` is high in the cycle after an edge that sampled `cs_n` low and `rc_n` high, and low otherwise. While `dout_oe` is low, `dout` is zero.
- R7: With `byte_sel` sampled 0, `dout[15:8]` carries the upper result byte and `dout[7:0]` the lower byte. With `byte_sel` sampled 1, the two bytes are exchanged.
- R8: With `TWOS_COMP`=1, the reported code is the stored sample with bit 15 inverted. With `TWOS_COMP`=0, it is the stored sample unchanged.
- R9: While `rst` is asserted and immediately after it is released, `busy_n` is 1, `dout_oe` is 0, `dout` is 0, and the stored result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| rc_n | input | 1 | Read/convert strobe; low requests conversion, high requests a read |
| byte_sel | input | 1 | Selects swapped byte lanes on the bus |
| ain | input | DATA_W | Test input carrying the analog sample as a code |
| busy_n | output | 1 | Low while a conversion is in progress |
| dout | output | DATA_W | Registered output data bus |
| dout_oe | output | 1 | Output enable that stands in for the tri-state pad control |

## Verification
The start qualifier is driven with pulses shorter than, equal to and longer than the minimum width. This separates an off-by-one in pulse counting from a qualifier that fires again while a pulse is held. Starts are also issued in the middle of a conversion and inside the acquisition window; a design that gates only on the busy flag, and not on the acquisition window, fails here. Samples with the top bit set and with it clear (0x0000, 0x7FFF, 0x8000, 0xFFFF, and mixed patterns) are read with both lane settings, on one instance per coding. This exposes a swapped or missing MSB inversion and crossed byte lanes, and the sample changes after capture show whether the held value or the live input is reported.

// File: rtl/samp_conv_pkg.sv
package samp_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_ACQ  = 2'd2
  } seq_state_t;

  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    return $clog2(((a > b) ? a : b) + 1);
  endfunction

endpackage

// File: rtl/start_qualifier.sv
module start_qualifier #(
  parameter int unsigned START_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rc_n,
  output logic start_p
);
  localparam int unsigned LW = $clog2(START_CYC + 1);

  logic          both_low;
  logic [LW-1:0] lo_cnt;

  assign both_low = !cs_n && !rc_n;

  // saturating run-length counter of the joint low condition
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
    end else if (!both_low) begin
      lo_cnt <= '0;
    end else if (lo_cnt != LW'(START_CYC)) begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assign start_p = both_low && (lo_cnt == LW'(START_CYC - 1));

  // R3: one strobe per low pulse, never on two edges in a row
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !start_p);

  // R1: a strobe needs the lines low on the previous edge as well when START_CYC > 1
  a_r1_pulse_width: assert property (@(posedge clk) disable iff (rst)
    (start_p && START_CYC > 1) |-> $past(!cs_n && !rc_n));

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import samp_conv_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CONV_CYC = 1750,
  parameter int unsigned ACQ_CYC  = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic [DATA_W-1:0] ain,
  output logic              busy_n,
  output logic [DATA_W-1:0] result
);
  localparam int unsigned CW = cnt_bits(CONV_CYC, ACQ_CYC);

  seq_state_t        state;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      hold   <= '0;
      result <= '0;
      busy_n <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_p) begin
            state  <= ST_CONV;
            cnt    <= CW'(CONV_CYC - 1);
            hold   <= ain;
            busy_n <= 1'b0;
          end
        end
        ST_CONV: begin
          if (cnt == '0) begin
            result <= hold;
            busy_n <= 1'b1;
            state  <= ST_ACQ;
            cnt    <= CW'(ACQ_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACQ: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a mid-conversion strobe neither ends busy nor recaptures the sample
  a_r3_ignore_restart: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && cnt != '0 && start_p) |=> (!busy_n && $stable(hold)));

  // R4: busy flag tracks the conversion phase
  a_r4_busy_in_conv: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV) |-> !busy_n);

  // R2: the frozen sample is the input seen at the qualifying edge
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> (hold == $past(ain)));

  // R5: result only moves when busy returns high
  a_r5_result_stable: assert property (@(posedge clk) disable iff (rst)
    !$rose(busy_n) |-> $stable(result));

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned DATA_W    = 16,
  parameter bit          TWOS_COMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rc_n,
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  localparam int unsigned HB = DATA_W / 2;

  logic [DATA_W-1:0] coded;
  logic [DATA_W-1:0] swapped;
  logic              rd_en;

  generate
    if (TWOS_COMP) begin : g_twos
      assign coded = {~result[DATA_W-1], result[DATA_W-2:0]};
    end else begin : g_straight
      assign coded = result;
    end
  endgenerate

  assign swapped = {coded[HB-1:0], coded[DATA_W-1:HB]};
  assign rd_en   = !cs_n && rc_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_oe <= 1'b0;
      dout    <= '0;
    end else begin
      dout_oe <= rd_en;
      dout    <= rd_en ? (byte_sel ? swapped : coded) : '0;
    end
  end

  // R6: a disabled bus carries zero
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> (dout == '0));

  // R6: enable follows a read request, never a convert request
  a_r6_read_only: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(rc_n && !cs_n));

endmodule

// File: rtl/samp_conv_if.sv
module samp_conv_if #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned START_CYC = 10,
  parameter int unsigned CONV_CYC  = 1750,
  parameter int unsigned ACQ_CYC   = 250,
  parameter bit          TWOS_COMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rc_n,
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] ain,
  output logic              busy_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  logic              start_p;
  logic [DATA_W-1:0] result;

  start_qualifier #(.START_CYC(START_CYC)) u_qual (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rc_n(rc_n), .start_p(start_p)
  );

  conv_sequencer #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) u_seq (
    .clk(clk), .rst(rst), .start_p(start_p), .ain(ain),
    .busy_n(busy_n), .result(result)
  );

  out_stage #(.DATA_W(DATA_W), .TWOS_COMP(TWOS_COMP)) u_out (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rc_n(rc_n), .byte_sel(byte_sel),
    .result(result), .dout(dout), .dout_oe(dout_oe)
  );

  // R1: busy only falls after an edge that saw both lines low
  a_r1_start_cond: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> $past(!cs_n && !rc_n));

  // R9: the cycle right after reset shows idle outputs
  a_r9_post_reset: assert property (@(posedge clk)
    $past(rst) |-> (busy_n && !dout_oe && dout == '0));

endmodule

// File: tb/tb_samp_conv_if.sv
module tb_samp_conv_if;
  localparam int SC = 3;
  localparam int CC = 12;
  localparam int AC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rc_n = 1'b1, byte_sel = 1'b0;
  logic [15:0] ain = 16'h0000;
  logic        busy_n, dout_oe, busy_n_sb, dout_oe_sb;
  logic [15:0] dout, dout_sb;

  int n_cmp = 0;
  int n_bad = 0;
  int falls = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  samp_conv_if #(.START_CYC(SC), .CONV_CYC(CC), .ACQ_CYC(AC), .TWOS_COMP(1'b1)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rc_n(rc_n), .byte_sel(byte_sel), .ain(ain),
    .busy_n(busy_n), .dout(dout), .dout_oe(dout_oe)
  );

  samp_conv_if #(.START_CYC(SC), .CONV_CYC(CC), .ACQ_CYC(AC), .TWOS_COMP(1'b0)) dut_sb (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rc_n(rc_n), .byte_sel(byte_sel), .ain(ain),
    .busy_n(busy_n_sb), .dout(dout_sb), .dout_oe(dout_oe_sb)
  );

  // behavioural reference: remaining-time counters and a queue of pending results
  int          m_run;
  int          m_left;
  int          m_acq;
  logic [15:0] m_res;
  logic        m_busy_n, m_oe;
  logic [15:0] m_dout_tc, m_dout_sb;
  logic [15:0] pend[$];

  function automatic logic [15:0] lanes(input logic [15:0] v, input logic sw);
    return sw ? {v[7:0], v[15:8]} : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_left = 0; m_acq = 0; m_res = 16'h0;
      m_busy_n = 1'b1; m_oe = 1'b0; m_dout_tc = 16'h0; m_dout_sb = 16'h0;
      pend.delete();
    end else begin
      bit fire;
      m_oe      = !cs_n && rc_n;
      m_dout_tc = m_oe ? lanes(m_res ^ 16'h8000, byte_sel) : 16'h0;
      m_dout_sb = m_oe ? lanes(m_res, byte_sel) : 16'h0;
      fire  = (!cs_n && !rc_n) && (m_run == SC - 1);
      m_run = (!cs_n && !rc_n) ? ((m_run < SC) ? m_run + 1 : SC) : 0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_res = pend.pop_front();
          m_busy_n = 1'b1;
          m_acq = AC;
        end
      end else if (m_acq > 0) begin
        m_acq = m_acq - 1;
      end else if (fire) begin
        pend.push_back(ain);
        m_left = CC;
        m_busy_n = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // clock-by-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R4 busy_n", {15'h0, busy_n}, {15'h0, m_busy_n});
      chk("R6 dout_oe", {15'h0, dout_oe}, {15'h0, m_oe});
      chk("R7 dout twos", dout, m_dout_tc);
      chk("R8 dout straight", dout_sb, m_dout_sb);
    end
  end

  logic prev_busy_n = 1'b1;
  always @(negedge clk) begin
    if (prev_busy_n && !busy_n) falls++;
    prev_busy_n <= busy_n;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic lines(input logic c, input logic r, input logic b);
    cs_n = c; rc_n = r; byte_sel = b;
  endtask

  task automatic convert(input logic [15:0] v);
    ain = v;
    lines(1'b0, 1'b0, 1'b0);
    cyc(SC);
    lines(1'b1, 1'b1, 1'b0);
  endtask

  task automatic read_word(input logic b, input logic [15:0] v);
    lines(1'b0, 1'b1, b);
    cyc(1);
    @(negedge clk);
    chk("R8 twos code", dout, lanes(v ^ 16'h8000, b));
    chk("R7 straight lanes", dout_sb, lanes(v, b));
    #1;
    lines(1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    int f0;
    lines(1'b1, 1'b1, 1'b0);
    cyc(4);
    @(negedge clk);
    chk("R9 busy in reset", {15'h0, busy_n}, 16'h1);
    #1; rst = 1'b0;
    cyc(1);
    @(negedge clk);
    chk("R9 busy_n", {15'h0, busy_n}, 16'h1);
    chk("R9 oe", {15'h0, dout_oe}, 16'h0);
    chk("R9 dout", dout, 16'h0);
    #1;
    read_word(1'b0, 16'h0000);          // R9 stored result is zero

    // R1: pulse one cycle short
    ain = 16'h1234;
    lines(1'b0, 1'b0, 1'b0);
    cyc(SC - 1);
    lines(1'b1, 1'b1, 1'b0);
    cyc(3);
    @(negedge clk);
    chk("R1 short pulse", {15'h0, busy_n}, 16'h1);
    #1;

    // R4 / R2 / R3: full pulse, then change input and retry mid-conversion
    convert(16'h1234);
    @(negedge clk);
    chk("R4 busy low", {15'h0, busy_n}, 16'h0);
    #1;
    ain = 16'hABCD;
    cyc(2);
    f0 = falls;
    lines(1'b0, 1'b0, 1'b0);
    cyc(5);
    lines(1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R3 restart ignored", {15'h0, busy_n}, 16'h0);
    #1;
    cyc(12);
    chk("R3 no extra start", 16'(falls - f0), 16'h0);
    chk("R5 busy high", {15'h0, busy_n}, 16'h1);
    read_word(1'b0, 16'h1234);          // R2 held sample reported
    read_word(1'b1, 16'h1234);          // R7 swapped lanes
    cyc(1);
    @(negedge clk);
    chk("R6 oe off", {15'h0, dout_oe}, 16'h0);
    chk("R6 bus zero", dout, 16'h0);
    #1;

    // R3: start inside acquisition window
    convert(16'h8000);
    cyc(CC - SC + SC);
    f0 = falls;
    convert(16'h5555);
    cyc(1);
    @(negedge clk);
    chk("R3 acq window ignored", 16'(falls - f0), 16'h0);
    #1;
    cyc(AC + 2);
    read_word(1'b0, 16'h8000);          // R5 last completed result

    // R8: coding corners under both lane settings
    foreach (pat_list[i]) begin
      convert(pat_list[i]);
      cyc(CC + AC + 2);
      read_word(1'b0, pat_list[i]);
      read_word(1'b1, pat_list[i]);
    end

    // R3: a long held pulse starts exactly one conversion
    f0 = falls;
    ain = 16'h0F0F;
    lines(1'b0, 1'b0, 1'b0);
    cyc(CC + AC + 6);
    lines(1'b1, 1'b1, 1'b0);
    cyc(3);
    chk("R3 held pulse once", 16'(falls - f0), 16'h1);
    read_word(1'b0, 16'h0F0F);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [15:0] pat_list [4] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'hC3A5};

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule